// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block models the keyboard end of a byte-serial keyboard link. The host sends command bytes. The block decodes each one and places its answer in a 256-byte output queue, which the host side drains one byte per read strobe. Key events from the keyboard logic arrive as a 7-bit code plus a press flag and are queued as single bytes. The block holds one filter per lock key, so a lock key that is physically pressed twice only reports one press and one release.

Two commands flush the queue before answering: the reset command and the layout query. The LED command is not answered. Instead, the byte that follows it is taken as LED data and is not decoded. Command bytes count only while the transmit-enable input is high. Response bytes enter the queue one per cycle, starting on the edge after the command is accepted. A key event in the same cycle takes the queue slot, and the response byte waits one cycle.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `level_o` is 0 and `rd_data_o` reads 0x00.
- R2: An accepted command 0x01 empties the queue on its acceptance edge, then queues 0xFF, 0x04, 0x7F in that order.
- R3: An accepted command 0x07 or 0x0F empties the queue on its acceptance edge, then queues 0xFE, 0x21 in that order.
- R4: An accepted command 0x0E queues nothing. The next accepted command byte, whatever its value, is consumed as LED data and has no effect on the queue.
- R5: Any other accepted command byte leaves the queue unchanged.
- R6: While `tx_en_i` is low, `cmd_valid_i` has no effect on the queue or on the LED-data state.
- R7: A key press queues the 7-bit code with bit 7 clear. A key release queues the code with bit 7 set (code | 0x80).
- R8: Each lock key (codes set by `LOCK_CODES`, defaults 0x77 and 0x62) keeps a 2-bit state that starts at 0. A press XORs it with 1 and a release XORs it with 2. A press that leaves the state at 2 is dropped, and a release that leaves it at 3 is dropped.
- R9: The queue holds `DEPTH` (256) bytes. A push while it is full is dropped. A read strobe while it is empty changes nothing, and `rd_data_o` is 0x00 whenever it is empty.
- R10: A response byte due in the same cycle as a key event waits one cycle, so the key byte is queued ahead of it. At most one byte enters the queue per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Command path enable |
| cmd_valid_i | input | 1 | A host command byte is present this cycle |
| cmd_data_i | input | 8 | Host command byte |
| key_valid_i | input | 1 | A key event is present this cycle |
| key_code_i | input | 7 | Keycode |
| key_press_i | input | 1 | 1 = press, 0 = release |
| rd_en_i | input | 1 | Pop the head byte of the queue |
| rd_data_o | output | 8 | Head byte of the queue, 0x00 when empty |
| level_o | output | 9 | Number of bytes in the queue |

## Verification
A key event or a read is visible on `level_o` and `rd_data_o` one edge after it is driven. A flush is visible on the acceptance edge itself. The N-th response byte lands N edges after acceptance, plus one edge for each colliding key event. The bench drives inputs on the falling edge and samples on a later falling edge. After each command it waits four full cycles, which covers the longest response, before the monitor drains the queue against the scoreboard. The collision case drives its key event exactly one cycle after the command, which pins the ordering the requirement demands.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam logic [7:0] CMD_RESET    = 8'h01;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;
  localparam logic [7:0] CMD_LED      = 8'h0E;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RESET  = 2'd1,
    SEQ_LAYOUT = 2'd2
  } seq_e;

  function automatic logic [7:0] resp_byte(seq_e kind, logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (kind == SEQ_RESET) begin
      case (idx)
        2'd0:    b = 8'hFF;
        2'd1:    b = 8'h04;
        default: b = 8'h7F;
      endcase
    end else if (kind == SEQ_LAYOUT) begin
      b = (idx == 2'd0) ? 8'hFE : 8'h21;
    end
    return b;
  endfunction

  function automatic logic [1:0] resp_last(seq_e kind);
    return (kind == SEQ_RESET) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_data_i,
  input  logic       stall_i,
  output logic       flush_o,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       led_armed_o
);
  seq_e       kind_q;
  logic [1:0] idx_q;
  logic       led_q;
  logic       accept, is_reset, is_layout, is_led;

  assign accept    = cmd_valid_i && tx_en_i;
  assign is_reset  = cmd_data_i == CMD_RESET;
  assign is_layout = (cmd_data_i == CMD_LAYOUT_A) || (cmd_data_i == CMD_LAYOUT_B);
  assign is_led    = cmd_data_i == CMD_LED;

  assign flush_o     = accept && !led_q && (is_reset || is_layout);
  // a restart discards the old sequence's pending byte
  assign push_o      = (kind_q != SEQ_IDLE) && !stall_i && !flush_o;
  assign data_o      = resp_byte(kind_q, idx_q);
  assign led_armed_o = led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= SEQ_IDLE;
      idx_q  <= '0;
      led_q  <= 1'b0;
    end else begin
      if (push_o) begin
        if (idx_q == resp_last(kind_q)) begin
          kind_q <= SEQ_IDLE;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
      if (accept) begin
        if (led_q) begin
          led_q <= 1'b0;
        end else if (is_led) begin
          led_q <= 1'b1;
        end else if (is_reset) begin
          kind_q <= SEQ_RESET;
          idx_q  <= '0;
        end else if (is_layout) begin
          kind_q <= SEQ_LAYOUT;
          idx_q  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter #(
  parameter int             N_LOCK     = 2,
  parameter int             CODE_W     = 7,
  parameter logic [N_LOCK*CODE_W-1:0] LOCK_CODES = {7'h62, 7'h77}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CODE_W-1:0] key_code_i,
  input  logic              key_press_i,
  output logic              push_o,
  output logic [CODE_W:0]   data_o
);
  logic [N_LOCK-1:0] drop;

  for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
    logic [1:0] st_q, st_nxt;
    logic       hit;
    assign hit    = key_valid_i && (key_code_i == LOCK_CODES[g*CODE_W +: CODE_W]);
    assign st_nxt = key_press_i ? (st_q ^ 2'b01) : (st_q ^ 2'b10);
    assign drop[g] = hit && (key_press_i ? (st_nxt == 2'd2) : (st_nxt == 2'd3));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  st_q <= 2'd0;
      else if (hit) st_q <= st_nxt;
    end
  end

  assign push_o = key_valid_i && !(|drop);
  assign data_o = {~key_press_i, key_code_i};
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0) && !flush_i;
  assign do_push = push_i && (flush_i || (cnt_q < CNT_W'(DEPTH)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      rptr_q <= '0;
      wptr_q <= do_push ? AW'(1) : '0;
      cnt_q  <= do_push ? CNT_W'(1) : '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + AW'(1);
      if (do_pop)  rptr_q <= rptr_q + AW'(1);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[flush_i ? '0 : wptr_q] <= push_data_i;
  end

  assign rd_data_o = (cnt_q == '0) ? '0 : mem[rptr_q];
  assign level_o   = cnt_q;
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder #(
  parameter int                  DEPTH      = 256,
  parameter int                  N_LOCK     = 2,
  parameter logic [N_LOCK*7-1:0] LOCK_CODES = {7'h62, 7'h77},
  localparam int                 CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_data_i,
  input  logic             key_valid_i,
  input  logic [6:0]       key_code_i,
  input  logic             key_press_i,
  input  logic             rd_en_i,
  output logic [7:0]       rd_data_o,
  output logic [CNT_W-1:0] level_o
);
  logic       key_push, seq_push, q_flush, led_armed;
  logic [7:0] key_byte, seq_byte;

  kbd_lock_filter #(
    .N_LOCK(N_LOCK), .CODE_W(7), .LOCK_CODES(LOCK_CODES)
  ) u_lock (
    .clk_i, .rst_ni, .key_valid_i, .key_code_i, .key_press_i,
    .push_o(key_push), .data_o(key_byte)
  );

  kbd_cmd_seq u_seq (
    .clk_i, .rst_ni, .tx_en_i, .cmd_valid_i, .cmd_data_i,
    .stall_i(key_push), .flush_o(q_flush), .push_o(seq_push),
    .data_o(seq_byte), .led_armed_o(led_armed)
  );

  kbd_byte_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_q (
    .clk_i, .rst_ni, .flush_i(q_flush),
    .push_i(key_push || seq_push),
    .push_data_i(key_push ? key_byte : seq_byte),
    .pop_i(rd_en_i), .rd_data_o, .level_o
  );
endmodule

// File: rtl/kbd_responder_chk.sv
module kbd_responder_chk #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_data_i,
  input logic             key_valid_i,
  input logic             rd_en_i,
  input logic [7:0]       rd_data_o,
  input logic [CNT_W-1:0] level_o,
  input logic             key_push,
  input logic             seq_push,
  input logic             q_flush,
  input logic             led_armed
);
  AST_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CNT_W'(DEPTH)); // R9
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (rd_data_o == 8'h00)); // R9
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && level_o != '0 && !key_push && !seq_push && !q_flush)
    |=> (level_o == $past(level_o) - CNT_W'(1))); // R9
  AST_KEY_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_push && !q_flush && !rd_en_i && level_o < CNT_W'(DEPTH))
    |=> (level_o == $past(level_o) + CNT_W'(1))); // R7
  AST_RESET_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && cmd_valid_i && cmd_data_i == 8'h01 && !led_armed)
    |=> (level_o <= CNT_W'(1))); // R2
  AST_LED_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_armed && tx_en_i && cmd_valid_i) |=> !led_armed); // R4
  AST_IDLE_CMD_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !tx_en_i && !key_valid_i && !rd_en_i && !seq_push)
    |=> $stable(level_o)); // R6
  AST_ONE_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_push && seq_push)); // R10
endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_kbd_responder.sv
module sim_kbd_responder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0, cmd_valid_i = 1'b0, key_valid_i = 1'b0;
  logic       key_press_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] cmd_data_i = 8'h00;
  logic [6:0] key_code_i = 7'h00;
  logic [7:0] rd_data_o;
  logic [8:0] level_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit  led_m = 0;
  int  lock_st[2] = '{0, 0};

  always #10 clk_i = ~clk_i;

  kbd_responder u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void push_m(logic [7:0] b);
    if (exp_q.size() < 256) exp_q.push_back(b);
  endfunction

  task automatic send_cmd(logic [7:0] b, bit en);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_data_i = b; tx_en_i = en;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; tx_en_i = 1'b0;
    if (en) begin
      if (led_m) led_m = 0;
      else if (b == 8'h0E) led_m = 1;
      else if (b == 8'h01) begin
        exp_q.delete(); push_m(8'hFF); push_m(8'h04); push_m(8'h7F);
      end else if (b == 8'h07 || b == 8'h0F) begin
        exp_q.delete(); push_m(8'hFE); push_m(8'h21);
      end
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic send_key(logic [6:0] c, bit press);
    int li;
    bit keep;
    @(negedge clk_i);
    key_valid_i = 1'b1; key_code_i = c; key_press_i = press;
    @(negedge clk_i);
    key_valid_i = 1'b0;
    keep = 1;
    li = (c == 7'h77) ? 0 : (c == 7'h62) ? 1 : -1;
    if (li >= 0) begin
      lock_st[li] = lock_st[li] ^ (press ? 1 : 2);
      if (press && lock_st[li] == 2) keep = 0;
      if (!press && lock_st[li] == 3) keep = 0;
    end
    if (keep) push_m(press ? {1'b0, c} : {1'b1, c});
  endtask

  // monitor: pop every queued byte and compare with the scoreboard
  task automatic drain(string req);
    while (level_o != 0) begin
      logic [7:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hXX;
      check(req, rd_data_o, e);
      rd_en_i = 1'b1;
      @(negedge clk_i);
      rd_en_i = 1'b0;
    end
    check({req, " leftover"}, exp_q.size(), 0);
    check({req, " empty read"}, rd_data_o, 0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 level", level_o, 0);
    check("R1 data", rd_data_o, 0);

    // R7 plain press/release
    send_key(7'h10, 1); send_key(7'h10, 0); send_key(7'h45, 1);
    check("R7 level", level_o, 3);
    drain("R7");

    // R2 flush then reset answer
    send_key(7'h11, 1); send_key(7'h12, 1);
    send_cmd(8'h01, 1);
    check("R2 level", level_o, 3);
    drain("R2");

    // R3 both layout codes
    send_key(7'h13, 0);
    send_cmd(8'h07, 1);
    drain("R3 07");
    send_cmd(8'h0F, 1);
    drain("R3 0F");

    // R4 LED byte swallowed, then commands decode again
    send_cmd(8'h0E, 1);
    check("R4 arm", level_o, 0);
    send_cmd(8'h01, 1);
    check("R4 led data", level_o, 0);
    send_cmd(8'h07, 1);
    drain("R4 after");

    // R5 unknown command
    send_key(7'h20, 1);
    send_cmd(8'h42, 1);
    check("R5 level", level_o, 1);
    drain("R5");

    // R6 disabled command path
    send_key(7'h33, 1);
    send_cmd(8'h01, 0);
    send_cmd(8'h0E, 0);
    send_cmd(8'h0F, 1);
    drain("R6");

    // R8 two full toggle cycles on both lock keys
    for (int n = 0; n < 2; n++) begin
      send_key(7'h77, 1); send_key(7'h77, 0);
      send_key(7'h77, 1); send_key(7'h77, 0);
      send_key(7'h62, 1); send_key(7'h62, 0);
      send_key(7'h62, 1); send_key(7'h62, 0);
    end
    check("R8 level", level_o, 8);
    drain("R8");

    // R9 overflow drop and empty pop
    for (int n = 0; n < 260; n++) send_key(7'(n), 1);
    check("R9 full", level_o, 256);
    drain("R9");
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check("R9 empty pop level", level_o, 0);
    check("R9 empty pop data", rd_data_o, 0);

    // R10 key event collides with first response byte
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_data_i = 8'h07; tx_en_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; tx_en_i = 1'b0;
    key_valid_i = 1'b1; key_code_i = 7'h05; key_press_i = 1'b1;
    @(negedge clk_i);
    key_valid_i = 1'b0;
    check("R10 after key", level_o, 1);
    check("R10 head", rd_data_o, 8'h05);
    repeat (3) @(negedge clk_i);
    exp_q.delete();
    exp_q.push_back(8'h05); exp_q.push_back(8'hFE); exp_q.push_back(8'h21);
    drain("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule